// File: doc/BRIEF.md
# Tag-Only Cache Emulator with Hit and Reference Counters

This block watches a stream of captured bus words, one per sample strobe, and takes a memory address from each one. It runs that address through a cache model that keeps tags, valid bits and recency state but stores no data. On every accepted sample it adds one to a reference counter, and it also adds one to a hit counter when the model finds the line. The hit ratio can therefore be read at any time while the observed machine keeps running. Nothing is traced or buffered for later analysis.

Three configuration inputs set the model's geometry and can be changed between samples: the number of ways in use (one, two or four), the line size (4 to 32 bytes) and the victim policy (least recently used, or pseudo-random from a shift register). The set count and the widths are parameters. A one-cycle clear command empties the model and zeroes both counters. Every sample is classified in the cycle it arrives, so the block accepts a sample on every clock and never stalls the sampler.

Top module: `cache_hit_monitor`

## Requirements
- R1: The address is bits [ADDR_LSB +: ADDR_W] of `sample_word`. With the default parameters these are bits 31:0. The other bits of the word have no effect.
- R2: `cfg_blk` values 0, 1, 2 and 3 select lines of 4, 8, 16 and 32 bytes. The offset is the lowest 2+`cfg_blk` address bits. The next log2(SETS) bits, 6 by default, are the set index. All remaining upper bits form the tag. Two addresses in the same line hit each other.
- R3: `cfg_assoc` = 0 selects direct-mapped, 1 selects two ways and 2 or 3 selects four ways. Only ways 0 to n-1 of each set are looked up or filled.
- R4: A sample is a hit when an active way of its set is valid and holds its tag. Otherwise it is a miss, and its line is installed in a victim way of that set.
- R5: The victim is the lowest-numbered active way that is invalid. Only when every active way is valid does the replacement policy choose.
- R6: With `cfg_repl` = 0, the victim is the active way that was referenced least recently. Both hits and fills count as references.
- R7: With `cfg_repl` = 1, the victim is way (L[1:0] AND (n-1)), where L is a 16-bit register. L is 16'hACE1 after reset or clear. It steps to {L[14:0], L[15]^L[13]^L[12]^L[10]} once for every miss, including misses that fill an invalid way.
- R8: A sample with `sample_valid` high at a clock edge is counted at that edge. `ref_count` gains one for every such sample and `hit_count` gains one for every hit. A sample is accepted on every clock edge without gaps.
- R9: `clear` high at an edge invalidates every line, zeroes both counters and reseeds L. A sample at the same edge is discarded.
- R10: Each counter stops at all ones. It does not wrap.
- R11: After reset both counters read zero and every line is invalid.
- R12: A change of `cfg_assoc`, `cfg_blk` or `cfg_repl` applies from the next sample and needs no clear. Lines held in ways that are no longer active are not seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear | input | 1 | Invalidate all lines and zero the counters |
| sample_valid | input | 1 | Sample strobe |
| sample_word | input | SAMPLE_W (64) | Captured word carrying the address |
| cfg_assoc | input | 2 | Way count select |
| cfg_blk | input | 2 | Line size select |
| cfg_repl | input | 1 | Victim policy: 0 least recent, 1 pseudo-random |
| hit_count | output | CNT_W (32) | Number of hits |
| ref_count | output | CNT_W (32) | Number of accepted samples |

## Verification
The assertions check the counter rules on every cycle:
- the hit count never exceeds the reference count;
- a clear zeroes both counters;
- an accepted sample moves the reference count by exactly one, and the hit count moves only on a hit;
- idle cycles leave both counters unchanged;
- a saturated counter stays saturated.

Whether a given sample should have been a hit depends on the line size, the way count, the recency order and the random register. Only the bench's scenarios can show this. The bench compares both counters after every sample with a model that keeps time stamps and applies the same configuration.

// File: rtl/cemu_pkg.sv
package cemu_pkg;

  typedef enum logic [1:0] {
    ASSOC_DIRECT = 2'd0,
    ASSOC_TWO    = 2'd1,
    ASSOC_FOUR   = 2'd2,
    ASSOC_FOUR_B = 2'd3
  } assoc_e;

  typedef enum logic {
    REPL_OLDEST = 1'b0,
    REPL_RANDOM = 1'b1
  } repl_e;

  localparam int unsigned LFSR_W = 16;
  localparam logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1;

  // Number of ways enabled by a select code, limited to the ways built.
  function automatic int unsigned active_ways(input logic [1:0] sel, input int unsigned built);
    int unsigned n;
    case (assoc_e'(sel))
      ASSOC_DIRECT: n = 1;
      ASSOC_TWO:    n = 2;
      default:      n = 4;
    endcase
    if (n > built) n = built;
    return n;
  endfunction

endpackage

// File: rtl/cemu_rst_sync.sv
module cemu_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/cemu_addr_split.sv
module cemu_addr_split #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned IDX_W  = 6,
  localparam int unsigned TAG_W = ADDR_W - 2 - IDX_W
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        blk_sel,
  output logic [IDX_W-1:0]  set_idx,
  output logic [TAG_W-1:0]  line_tag
);
  logic [ADDR_W-3:0] line_addr;

  // The lowest two bits are always inside the line; blk_sel drops up to three more.
  always_comb begin
    line_addr = addr[ADDR_W-1:2] >> blk_sel;
    {line_tag, set_idx} = line_addr;
  end
endmodule

// File: rtl/cemu_lfsr.sv
module cemu_lfsr
  import cemu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reseed,
  input  logic              step,
  output logic [LFSR_W-1:0] state
);
  logic [LFSR_W-1:0] state_d;
  logic              state_en;

  always_comb begin
    state_en = reseed | step;
    if (reseed) state_d = LFSR_SEED;
    else        state_d = {state[14:0], state[15] ^ state[13] ^ state[12] ^ state[10]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        state <= LFSR_SEED;
    else if (state_en) state <= state_d;
  end
endmodule

// File: rtl/cemu_sat_counter.sv
module cemu_sat_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             zero,
  input  logic             inc,
  output logic [CNT_W-1:0] count
);
  logic [CNT_W-1:0] count_d;
  logic             count_en;
  logic             at_top;

  always_comb begin
    at_top   = &count;
    count_en = zero | (inc & ~at_top);
    count_d  = zero ? '0 : count + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        count <= '0;
    else if (count_en) count <= count_d;
  end
endmodule

// File: rtl/cemu_way_select.sv
module cemu_way_select #(
  parameter int unsigned WAYS  = 4,
  parameter int unsigned TAG_W = 24,
  localparam int unsigned AGE_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0]             act,
  input  logic [WAYS-1:0]             valid_row,
  input  logic [WAYS-1:0][TAG_W-1:0]  tag_row,
  input  logic [WAYS-1:0][AGE_W-1:0]  age_row,
  input  logic [TAG_W-1:0]            req_tag,
  input  logic                        use_rand,
  input  logic [AGE_W-1:0]            rand_way,
  output logic                        hit,
  output logic [AGE_W-1:0]            sel_way,
  output logic [WAYS-1:0][AGE_W-1:0]  age_nxt
);
  logic [AGE_W-1:0] hit_way, free_way, old_way, old_age, sel_age;
  logic             free_any, old_any;

  // Lookup and victim choice. Age 0 is the most recent; larger ages are older.
  always_comb begin
    hit      = 1'b0;
    hit_way  = '0;
    free_any = 1'b0;
    free_way = '0;
    for (int i = WAYS - 1; i >= 0; i--) begin
      if (act[i] && valid_row[i] && (tag_row[i] == req_tag)) begin
        hit     = 1'b1;
        hit_way = AGE_W'(i);
      end
      if (act[i] && !valid_row[i]) begin
        free_any = 1'b1;
        free_way = AGE_W'(i);
      end
    end
    old_any = 1'b0;
    old_way = '0;
    old_age = '0;
    for (int i = 0; i < WAYS; i++) begin
      if (act[i] && (!old_any || (age_row[i] > old_age))) begin
        old_any = 1'b1;
        old_way = AGE_W'(i);
        old_age = age_row[i];
      end
    end
    if (hit)           sel_way = hit_way;
    else if (free_any) sel_way = free_way;
    else if (use_rand) sel_way = rand_way;
    else               sel_way = old_way;
  end

  // Recency update over all ways keeps the ages a permutation of 0..WAYS-1.
  always_comb begin
    sel_age = age_row[sel_way];
    for (int i = 0; i < WAYS; i++) begin
      if (AGE_W'(i) == sel_way)      age_nxt[i] = '0;
      else if (age_row[i] < sel_age) age_nxt[i] = age_row[i] + 1'b1;
      else                           age_nxt[i] = age_row[i];
    end
  end
endmodule

// File: rtl/cache_hit_monitor.sv
module cache_hit_monitor
  import cemu_pkg::*;
#(
  parameter int unsigned SAMPLE_W = 64,
  parameter int unsigned ADDR_LSB = 0,
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned SETS     = 64,
  parameter int unsigned WAYS     = 4,
  parameter int unsigned CNT_W    = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clear,
  input  logic                sample_valid,
  input  logic [SAMPLE_W-1:0] sample_word,
  input  logic [1:0]          cfg_assoc,
  input  logic [1:0]          cfg_blk,
  input  logic                cfg_repl,
  output logic [CNT_W-1:0]    hit_count,
  output logic [CNT_W-1:0]    ref_count
);
  localparam int unsigned IDX_W = $clog2(SETS);
  localparam int unsigned TAG_W = ADDR_W - 2 - IDX_W;
  localparam int unsigned AGE_W = $clog2(WAYS);

  logic rst_sync_n;
  logic take, lk_hit, fill_en;
  logic [ADDR_W-1:0]  addr;
  logic [IDX_W-1:0]   set_idx;
  logic [TAG_W-1:0]   req_tag;
  logic [WAYS-1:0]    act;
  logic [AGE_W-1:0]   rand_way, sel_way, way_mask;
  logic [LFSR_W-1:0]  lfsr_state;
  logic [WAYS-1:0][AGE_W-1:0]            age_nxt;
  logic [SETS-1:0][WAYS-1:0][TAG_W-1:0]  tag_q;
  logic [SETS-1:0][WAYS-1:0]             valid_q;
  logic [SETS-1:0][WAYS-1:0][AGE_W-1:0]  age_q;
  logic [SETS-1:0][WAYS-1:0][AGE_W-1:0]  age_init;

  cemu_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n));

  assign addr = sample_word[ADDR_LSB +: ADDR_W];

  cemu_addr_split #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_split (
    .addr(addr), .blk_sel(cfg_blk), .set_idx(set_idx), .line_tag(req_tag)
  );

  // Active way mask and random victim limited to the active ways.
  always_comb begin
    int unsigned n;
    n        = active_ways(cfg_assoc, WAYS);
    way_mask = AGE_W'(n - 1);
    for (int i = 0; i < WAYS; i++) act[i] = (i < n);
    rand_way = lfsr_state[AGE_W-1:0] & way_mask;
  end

  cemu_way_select #(.WAYS(WAYS), .TAG_W(TAG_W)) u_sel (
    .act(act), .valid_row(valid_q[set_idx]), .tag_row(tag_q[set_idx]),
    .age_row(age_q[set_idx]), .req_tag(req_tag), .use_rand(cfg_repl == REPL_RANDOM),
    .rand_way(rand_way), .hit(lk_hit), .sel_way(sel_way), .age_nxt(age_nxt)
  );

  always_comb begin
    take    = sample_valid & ~clear;
    fill_en = take & ~lk_hit;
  end

  // Starting recency order: way w has age w in every set.
  generate
    for (genvar s = 0; s < SETS; s++) begin : g_set
      for (genvar w = 0; w < WAYS; w++) begin : g_way
        assign age_init[s][w] = AGE_W'(w);
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      valid_q <= '0;
      age_q   <= age_init;
    end else if (clear) begin
      valid_q <= '0;
      age_q   <= age_init;
    end else if (take) begin
      valid_q[set_idx][sel_way] <= 1'b1;
      age_q[set_idx]            <= age_nxt;
    end
  end

  // Tag storage needs no reset: valid bits gate every compare.
  always_ff @(posedge clk) begin
    if (fill_en) tag_q[set_idx][sel_way] <= req_tag;
  end

  cemu_lfsr u_lfsr (
    .clk(clk), .rst_n(rst_sync_n), .reseed(clear), .step(fill_en), .state(lfsr_state)
  );

  cemu_sat_counter #(.CNT_W(CNT_W)) u_ref_cnt (
    .clk(clk), .rst_n(rst_sync_n), .zero(clear), .inc(take), .count(ref_count)
  );

  cemu_sat_counter #(.CNT_W(CNT_W)) u_hit_cnt (
    .clk(clk), .rst_n(rst_sync_n), .zero(clear), .inc(take & lk_hit), .count(hit_count)
  );
endmodule

// File: rtl/cemu_chk.sv
module cemu_chk #(
  parameter int unsigned CNT_W = 32
) (
  input logic             clk,
  input logic             rst_sync_n,
  input logic             clear,
  input logic             sample_valid,
  input logic             lk_hit,
  input logic [CNT_W-1:0] hit_count,
  input logic [CNT_W-1:0] ref_count
);
  localparam logic [CNT_W-1:0] TOP = '1;

  AST_HIT_NOT_ABOVE_REF: assert property (@(posedge clk) disable iff (!rst_sync_n)
    hit_count <= ref_count); // R8

  AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!rst_sync_n)
    clear |=> (hit_count == '0) && (ref_count == '0)); // R9

  AST_REF_STEPS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (sample_valid && !clear && ref_count != TOP) |=> ref_count == $past(ref_count) + 1'b1); // R8

  AST_HIT_STEPS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (sample_valid && !clear && lk_hit && hit_count != TOP) |=> hit_count == $past(hit_count) + 1'b1); // R4

  AST_MISS_HOLDS_HITS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (sample_valid && !clear && !lk_hit) |=> $stable(hit_count)); // R4

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!sample_valid && !clear) |=> $stable(hit_count) && $stable(ref_count)); // R8

  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ref_count == TOP && !clear) |=> ref_count == TOP); // R10
endmodule

bind cache_hit_monitor cemu_chk #(.CNT_W(CNT_W)) u_cemu_chk (
  .clk(clk), .rst_sync_n(rst_sync_n), .clear(clear), .sample_valid(sample_valid),
  .lk_hit(lk_hit), .hit_count(hit_count), .ref_count(ref_count)
);

// File: tb/test_cache_hit_monitor.sv
module test_cache_hit_monitor;
  logic clk = 1'b0;
  logic rst_n, clear, sample_valid, cfg_repl;
  logic [63:0] sample_word;
  logic [1:0] cfg_assoc, cfg_blk;
  logic [31:0] hit_count, ref_count;
  logic [3:0] sat_hit, sat_ref;

  int checks = 0, errors = 0, cycles = 0;

  // Model state
  bit          m_val   [64][4];
  logic [23:0] m_tag   [64][4];
  int          m_stamp [64][4];
  int          m_time, m_ref, m_hit;
  logic [15:0] m_lfsr;

  always #10 clk = ~clk;

  cache_hit_monitor i_cache_hit_monitor (
    .clk(clk), .rst_n(rst_n), .clear(clear), .sample_valid(sample_valid),
    .sample_word(sample_word), .cfg_assoc(cfg_assoc), .cfg_blk(cfg_blk),
    .cfg_repl(cfg_repl), .hit_count(hit_count), .ref_count(ref_count)
  );

  cache_hit_monitor #(.CNT_W(4)) i_sat (
    .clk(clk), .rst_n(rst_n), .clear(clear), .sample_valid(sample_valid),
    .sample_word(sample_word), .cfg_assoc(cfg_assoc), .cfg_blk(cfg_blk),
    .cfg_repl(cfg_repl), .hit_count(sat_hit), .ref_count(sat_ref)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic void model_clear();
    for (int s = 0; s < 64; s++)
      for (int w = 0; w < 4; w++) begin
        m_val[s][w]   = 1'b0;
        m_stamp[s][w] = 0;
      end
    m_ref = 0; m_hit = 0; m_lfsr = 16'hACE1;
  endfunction

  function automatic bit model_access(input logic [31:0] a);
    int nw, off, idx, vic;
    logic [23:0] tg;
    bit hit;
    nw  = (cfg_assoc == 2'd0) ? 1 : (cfg_assoc == 2'd1) ? 2 : 4;
    off = 2 + int'(cfg_blk);
    idx = int'((a >> off) & 32'h3F);
    tg  = 24'(a >> (off + 6));
    m_time++;
    hit = 1'b0;
    for (int w = 0; w < nw; w++)
      if (m_val[idx][w] && m_tag[idx][w] == tg) begin
        hit = 1'b1;
        m_stamp[idx][w] = m_time;
      end
    if (!hit) begin
      vic = -1;
      for (int w = nw - 1; w >= 0; w--) if (!m_val[idx][w]) vic = w;
      if (vic < 0) begin
        if (cfg_repl) vic = int'(m_lfsr[1:0]) & (nw - 1);
        else begin
          vic = 0;
          for (int w = 1; w < nw; w++) if (m_stamp[idx][w] < m_stamp[idx][vic]) vic = w;
        end
      end
      m_val[idx][vic] = 1'b1;
      m_tag[idx][vic] = tg;
      m_stamp[idx][vic] = m_time;
      m_lfsr = {m_lfsr[14:0], m_lfsr[15] ^ m_lfsr[13] ^ m_lfsr[12] ^ m_lfsr[10]};
    end
    m_ref++;
    if (hit) m_hit++;
    return hit;
  endfunction

  function automatic int sat15(input int v);
    return (v > 15) ? 15 : v;
  endfunction

  // One sample; the counters are compared half a clock after the accepting edge.
  task automatic ref_addr(input logic [31:0] a, input string req);
    void'(model_access(a));
    sample_valid = 1'b1;
    sample_word  = {$urandom, a};
    @(negedge clk);
    sample_valid = 1'b0;
    check(ref_count == 32'(m_ref), {req, " ref_count"}, ref_count, m_ref);
    check(hit_count == 32'(m_hit), {req, " hit_count"}, hit_count, m_hit);
    check(sat_ref == 4'(sat15(m_ref)), "R10 saturated ref", sat_ref, sat15(m_ref));
    check(sat_hit == 4'(sat15(m_hit)), "R10 saturated hit", sat_hit, sat15(m_hit));
  endtask

  task automatic do_clear(input bit with_sample);
    clear = 1'b1;
    sample_valid = with_sample;
    sample_word = 64'h0000_0000_0000_1000;
    @(negedge clk);
    clear = 1'b0;
    sample_valid = 1'b0;
    model_clear();
    check(ref_count == 0 && hit_count == 0, "R9 clear zeroes", ref_count + hit_count, 0);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        errors++;
        $display("FAIL watchdog actual %0d expected %0d", cycles, 150000);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    logic [31:0] bsz;
    void'($urandom(32'd12345));
    rst_n = 1'b0; clear = 1'b0; sample_valid = 1'b0; sample_word = '0;
    cfg_assoc = 2'd2; cfg_blk = 2'd0; cfg_repl = 1'b0;
    m_time = 0;
    model_clear();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R11: counters zero after reset; first look-up misses (all lines invalid)
    check(ref_count == 0 && hit_count == 0, "R11 reset counters", ref_count + hit_count, 0);
    ref_addr(32'h0000_1000, "R11 cold miss");
    check(hit_count == 0, "R11 cold miss hit_count", hit_count, 0);

    // R1: upper word bits are random on every sample and must not matter; R2 line sizes
    for (int b = 0; b < 4; b++) begin
      cfg_blk = 2'(b);
      do_clear(1'b0);
      bsz = 32'd4 << b;
      ref_addr(32'h0000_2000, "R2 first touch");
      ref_addr(32'h0000_2000 + bsz - 1, "R2 same line");
      check(hit_count == 1, "R2 last byte of line hits", hit_count, 1);
      ref_addr(32'h0000_2000 + bsz, "R2 next line");
      check(hit_count == 1, "R2 next line misses", hit_count, 1);
      ref_addr(32'h0000_2000, "R1 repeat");
    end

    // R3/R4: two tags mapping to one set conflict in direct-mapped, coexist in two-way
    cfg_blk = 2'd0; cfg_repl = 1'b0;
    cfg_assoc = 2'd0; do_clear(1'b0);
    for (int k = 0; k < 3; k++) begin
      ref_addr(32'h0000_0100, "R3 direct A");
      ref_addr(32'h0001_0100, "R3 direct B");
    end
    check(hit_count == 0, "R3 direct-mapped thrash", hit_count, 0);
    cfg_assoc = 2'd1; do_clear(1'b0);
    for (int k = 0; k < 3; k++) begin
      ref_addr(32'h0000_0100, "R4 two-way A");
      ref_addr(32'h0001_0100, "R4 two-way B");
    end
    check(hit_count == 4, "R4 two-way holds both", hit_count, 4);

    // R5/R6: four-way fill A..D, touch A, insert E -> B evicted, A kept
    cfg_assoc = 2'd3; do_clear(1'b0);
    for (int k = 0; k < 4; k++) ref_addr(32'h0000_0040 + (32'(k) << 8), "R5 fill");
    ref_addr(32'h0000_0040, "R6 touch A");
    ref_addr(32'h0000_0440, "R6 insert E");
    ref_addr(32'h0000_0040, "R6 A survives");
    check(hit_count == 2, "R6 oldest evicted, A hit", hit_count, 2);
    ref_addr(32'h0000_0140, "R6 B evicted");
    check(hit_count == 2, "R6 B misses", hit_count, 2);

    // R7: random policy against the model
    cfg_repl = 1'b1; do_clear(1'b0);
    for (int k = 0; k < 200; k++) ref_addr(32'h0000_0080 + (32'($urandom_range(0, 7)) << 8), "R7 random victim");

    // R12: lines in ways 1..3 vanish when switching to direct-mapped
    cfg_repl = 1'b0; cfg_assoc = 2'd2; do_clear(1'b0);
    for (int k = 0; k < 4; k++) ref_addr(32'h0000_0300 + (32'(k) << 12), "R12 fill four");
    cfg_assoc = 2'd0;
    for (int k = 0; k < 4; k++) ref_addr(32'h0000_0300 + (32'(k) << 12), "R12 after switch");

    // R9: clear with a sample at the same edge drops the sample and forgets lines
    ref_addr(32'h0000_1000, "R9 preload");
    do_clear(1'b1);
    ref_addr(32'h0000_1000, "R9 line forgotten");
    check(hit_count == 0, "R9 sample after clear misses", hit_count, 0);

    // Random phase with changing configuration (R1..R8, R10, R12)
    for (int k = 0; k < 4000; k++) begin
      if (k % 250 == 0) begin
        cfg_assoc = 2'($urandom_range(0, 3));
        cfg_blk   = 2'($urandom_range(0, 3));
        cfg_repl  = 1'($urandom_range(0, 1));
      end
      ref_addr({16'h0, 4'($urandom_range(0, 5)), 12'($urandom_range(0, 511))}, "R8 random stream");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule